// File: doc/BRIEF.md
# Linked-List Block Mover

This block is a bus master that copies blocks of words from a source bus into local memory without help from the processor. Software prepares a chain of five-word job records in local memory. Each record names a source start address, a destination start address, a length in bytes, the access modifier code to present on every source cycle, and the address of the next record. Software then writes the address of the first record and sets the start bit. The engine reads each record, moves that block one word at a time, follows the link, and continues until it finishes a record whose last-record flag is set. The whole chain counts as one operation. At the end the engine raises a one-cycle interrupt and sets a completion flag that software can poll.

Each record is laid out as five 32-bit words at byte offsets 0, 4, 8, 12 and 16. In that order they hold the link, the source address, the destination address, the byte count, and a control word. In the control word, bits 5:0 carry the modifier code and bit 31 marks the last record. Source cycles and memory cycles each hold their request until they are acknowledged, so the timing inside each cycle is set by the responder. The engine only removes idle time between cycles. A source error response stops the chain, records which job record failed, and raises the interrupt.

Top module: `cdma_top`

## Requirements
- R1: After reset the engine is idle, issues no memory or source requests, holds `irq` low, and the status register (register select 1) reads zero.
- R2: On an accepted start, the engine reads the five words of the record at the head address, in order, at head+0, +4, +8, +12 and +16. The head address is held at register select 0.
- R3: For a record with byte count N, the engine issues N/4 source reads. They start at the record's source address and rise by 4 each time. Each read presents control bits 5:0 as the modifier code. Each returned word is written to local memory, starting at the record's destination address and rising by 4.
- R4: When a record ends without control bit 31 set, the engine fetches the record at that record's link word. A record with bit 31 set is the last one handled.
- R5: When the last record completes, the engine goes idle and sets status bit 1 (done). It raises `irq` for exactly one cycle, and the error bit stays clear.
- R6: A record with a byte count of zero causes no source or destination cycles, and the chain continues through it.
- R7: A source error response stops the engine at once, with no further requests of either kind. It sets status bit 2 (error) and leaves done clear. Register select 2 then holds the address of the failing record, and `irq` pulses once.
- R8: Writing the start bit (control bit 0 at register select 1) while busy has no effect: the running chain continues unchanged, and no second chain starts.
- R9: Writing the abort bit (control bit 1 at register select 1) while busy returns the engine to idle after the word in flight has been both read and written. Neither done nor `irq` is produced.
- R10: A memory or source request keeps its address, direction, data and modifier steady until it is acknowledged. The engine never requests both ports in the same cycle.
- R11: Status bit 0 reads 1 while the engine is busy. An accepted start clears the done and error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 head, 1 control/status, 2 failing record |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| irq | output | 1 | One-cycle completion or error interrupt |
| mem_req | output | 1 | Local memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| src_req | output | 1 | Source bus read request |
| src_addr | output | ADDR_W | Source byte address |
| src_mod | output | 6 | Source access modifier code |
| src_ack | input | 1 | Source acknowledge, one cycle |
| src_err | input | 1 | Source error response, one cycle |
| src_rdata | input | DATA_W | Source read data, valid with `src_ack` |

## Verification
The bench walks chains that include a zero-length record in the middle. A design that did not skip it would issue source reads that nobody expects, and one that ended there would leave the final record unfetched. It fires a start in the middle of a chain; an engine that restarted would fetch the head record again and show up as unexpected traffic. It places an error address in the second record and checks the failing-record register. A design that latched the wrong record would report the first one or the link target, and one that kept going would write memory after the error. An abort in the middle of a block checks that the read count and write count end equal, that fewer than all words moved, and that neither done nor the interrupt appears. A design that dropped the word in flight would leave one read without its write.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LINK,
    ST_READ,
    ST_WRITE
  } cdma_st_e;

  localparam int DESC_WORDS = 5;
  localparam int MOD_W      = 6;
  localparam int LAST_BIT   = 31;

  localparam logic [2:0] W_LINK = 3'd0;
  localparam logic [2:0] W_SRC  = 3'd1;
  localparam logic [2:0] W_DST  = 3'd2;
  localparam logic [2:0] W_LEN  = 3'd3;
  localparam logic [2:0] W_CTL  = 3'd4;

  localparam logic [1:0] SEL_HEAD = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_FAIL = 2'd2;
endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done_set,
  input  logic              err_set,
  input  logic [ADDR_W-1:0] err_desc,
  output logic [ADDR_W-1:0] head,
  output logic              go,
  output logic              abort,
  output logic              irq
);
  logic [ADDR_W-1:0] head_q, fail_q;
  logic              done_q, err_q, irq_q;
  logic              head_en, ctrl_wr;

  always_comb begin
    head_en = reg_wr && (reg_sel == SEL_HEAD);
    ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
    go      = ctrl_wr && reg_wdata[0] && !busy;
    abort   = ctrl_wr && reg_wdata[1] && busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      fail_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= done_set || err_set;
      if (head_en) head_q <= reg_wdata[ADDR_W-1:0];
      if (err_set) fail_q <= err_desc;
      if (go)            done_q <= 1'b0;
      else if (done_set) done_q <= 1'b1;
      if (go)            err_q <= 1'b0;
      else if (err_set)  err_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_HEAD: reg_rdata = 32'(head_q);
      SEL_CTRL: reg_rdata = {29'b0, err_q, done_q, busy};
      SEL_FAIL: reg_rdata = 32'(fail_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign head = head_q;
  assign irq  = irq_q;
endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  logic [ADDR_W-1:0] head,
  output logic              busy,
  output logic              done_set,
  output logic              err_set,
  output logic [ADDR_W-1:0] err_desc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  output logic [MOD_W-1:0]  src_mod,
  input  logic              src_ack,
  input  logic              src_err,
  input  logic [DATA_W-1:0] src_rdata
);
  localparam int STEP = DATA_W / 8;

  cdma_st_e          st_q, st_nx;
  logic [2:0]        idx_q;
  logic [ADDR_W-1:0] cur_q, lnk_q, sa_q, da_q;
  logic [DATA_W-1:0] len_q, buf_q;
  logic [MOD_W-1:0]  mod_q;
  logic              last_q, abt_q, abt_now, fetch_end, blk_end;

  always_comb begin
    abt_now   = abt_q || abort;
    fetch_end = (idx_q == 3'(DESC_WORDS - 1));
    blk_end   = (len_q <= DATA_W'(STEP));
    st_nx     = st_q;
    case (st_q)
      ST_IDLE:  if (go) st_nx = ST_FETCH;
      ST_FETCH: if (mem_ack && fetch_end)
                  st_nx = abt_now ? ST_IDLE : ((len_q == '0) ? ST_LINK : ST_READ);
      ST_LINK:  st_nx = (last_q || abt_now) ? ST_IDLE : ST_FETCH;
      ST_READ:  if (src_err) st_nx = ST_IDLE;
                else if (src_ack) st_nx = ST_WRITE;
      ST_WRITE: if (mem_ack)
                  st_nx = abt_now ? ST_IDLE : (blk_end ? ST_LINK : ST_READ);
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cur_q  <= '0;
      lnk_q  <= '0;
      sa_q   <= '0;
      da_q   <= '0;
      len_q  <= '0;
      buf_q  <= '0;
      mod_q  <= '0;
      last_q <= 1'b0;
      abt_q  <= 1'b0;
    end else begin
      abt_q <= (st_q == ST_IDLE) ? 1'b0 : abt_now;
      if (st_q == ST_IDLE && go) begin
        cur_q <= head;
        idx_q <= '0;
      end
      if (st_q == ST_FETCH && mem_ack) begin
        idx_q <= idx_q + 3'd1;
        case (idx_q)
          W_LINK:  lnk_q <= mem_rdata[ADDR_W-1:0];
          W_SRC:   sa_q  <= mem_rdata[ADDR_W-1:0];
          W_DST:   da_q  <= mem_rdata[ADDR_W-1:0];
          W_LEN:   len_q <= mem_rdata;
          W_CTL: begin
            mod_q  <= mem_rdata[MOD_W-1:0];
            last_q <= mem_rdata[LAST_BIT];
          end
          default: ;
        endcase
      end
      if (st_q == ST_LINK && !last_q) begin
        cur_q <= lnk_q;
        idx_q <= '0;
      end
      if (st_q == ST_READ && src_ack) buf_q <= src_rdata;
      if (st_q == ST_WRITE && mem_ack) begin
        sa_q  <= sa_q + ADDR_W'(STEP);
        da_q  <= da_q + ADDR_W'(STEP);
        len_q <= len_q - DATA_W'(STEP);
      end
    end
  end

  always_comb begin
    busy      = (st_q != ST_IDLE);
    done_set  = (st_q == ST_LINK) && last_q && !abt_now;
    err_set   = (st_q == ST_READ) && src_err;
    err_desc  = cur_q;
    mem_req   = (st_q == ST_FETCH) || (st_q == ST_WRITE);
    mem_we    = (st_q == ST_WRITE);
    mem_addr  = (st_q == ST_WRITE) ? da_q : (cur_q + ADDR_W'({idx_q, 2'b00}));
    mem_wdata = buf_q;
    src_req   = (st_q == ST_READ);
    src_addr  = sa_q;
    src_mod   = mod_q;
  end
endmodule

// File: rtl/cdma_top.sv
module cdma_top
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  output logic [MOD_W-1:0]  src_mod,
  input  logic              src_ack,
  input  logic              src_err,
  input  logic [DATA_W-1:0] src_rdata
);
  logic              busy, go, abort, done_set, err_set;
  logic [ADDR_W-1:0] head, err_desc;

  cdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .done_set(done_set), .err_set(err_set), .err_desc(err_desc),
    .head(head), .go(go), .abort(abort), .irq(irq)
  );

  cdma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .head(head),
    .busy(busy), .done_set(done_set), .err_set(err_set), .err_desc(err_desc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .src_req(src_req), .src_addr(src_addr), .src_mod(src_mod),
    .src_ack(src_ack), .src_err(src_err), .src_rdata(src_rdata)
  );
endmodule

// File: rtl/cdma_chk.sv
module cdma_chk
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              src_req,
  input logic [ADDR_W-1:0] src_addr,
  input logic [MOD_W-1:0]  src_mod,
  input logic              src_ack,
  input logic              src_err
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !src_req));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_src_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_ack && !src_err) |=> (src_req && $stable(src_addr) && $stable(src_mod)));

  assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && src_req));

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  assert_err_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && src_err) |=> (!src_req && !mem_req));
endmodule

bind cdma_top cdma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_cdma_top.sv
module tb_cdma_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        src_req;
  logic [31:0] src_addr;
  logic [5:0]  src_mod;
  logic        src_ack = 1'b0;
  logic        src_err = 1'b0;
  logic [31:0] src_rdata = '0;

  always #2 clk = ~clk;

  cdma_top dut (.*);

  int vec_cnt = 0, bad_cnt = 0;
  int irq_cnt = 0, wr_seen = 0, rd_seen = 0;
  int mdly = 0, sdly = 0, mpat = 0, spat = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] exp_f[$];
  logic [37:0] exp_s[$];
  logic [63:0] exp_w[$];

  function automatic logic [31:0] sval(input logic [31:0] a, input logic [5:0] m);
    return a ^ {m, 26'h0} ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vec_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (irq) irq_cnt++;

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (mdly > 0) mdly--;
      else begin
        if (mem_we) begin
          logic [63:0] e;
          wr_seen++;
          mem[mem_addr[11:2]] = mem_wdata;
          if (exp_w.size() == 0) chk(0, "R3 unexpected write", {mem_addr, mem_wdata}, 64'h0);
          else begin
            e = exp_w.pop_front();
            chk({mem_addr, mem_wdata} == e, "R3 write addr/data", {mem_addr, mem_wdata}, e);
          end
        end else begin
          logic [31:0] f;
          mem_rdata <= mem[mem_addr[11:2]];
          if (exp_f.size() == 0) chk(0, "R2 unexpected record fetch", 64'(mem_addr), 64'h0);
          else begin
            f = exp_f.pop_front();
            chk(mem_addr == f, "R2 record fetch address", 64'(mem_addr), 64'(f));
          end
        end
        mem_ack <= 1'b1;
        mdly = mpat % 3;
        mpat++;
      end
    end
  end

  // source responder and scoreboard monitor
  always @(negedge clk) begin
    if (src_ack || src_err) begin
      src_ack <= 1'b0;
      src_err <= 1'b0;
    end else if (src_req) begin
      if (sdly > 0) sdly--;
      else begin
        logic [37:0] e;
        rd_seen++;
        if (exp_s.size() == 0) chk(0, "R3 unexpected source read", 64'(src_addr), 64'h0);
        else begin
          e = exp_s.pop_front();
          chk({src_mod, src_addr} == e, "R3 source addr/modifier", 64'({src_mod, src_addr}), 64'(e));
        end
        if (src_addr[31:28] == 4'hE) src_err <= 1'b1;
        else begin
          src_rdata <= sval(src_addr, src_mod);
          src_ack <= 1'b1;
        end
        sdly = (spat % 2) * 2;
        spat++;
      end
    end
  end

  // driver: place a record in memory and queue what the engine must do with it
  task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt, input logic [31:0] sa,
                          input logic [31:0] da, input logic [31:0] len, input bit last,
                          input logic [5:0] md);
    mem[base[11:2]]     = nxt;
    mem[base[11:2] + 1] = sa;
    mem[base[11:2] + 2] = da;
    mem[base[11:2] + 3] = len;
    mem[base[11:2] + 4] = {last, 25'h0, md};
    for (int i = 0; i < 5; i++) exp_f.push_back(base + 32'(4 * i));
    for (int i = 0; i < int'(len / 4); i++) begin
      logic [31:0] a;
      a = sa + 32'(4 * i);
      exp_s.push_back({md, a});
      if (a[31:28] == 4'hE) break;
      exp_w.push_back({da + 32'(4 * i), sval(a, md)});
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n = 0;
    do begin
      rd(2'd1, s);
      n++;
    end while (s[0] && n < 5000);
    chk(!s[0], {req, " engine returned to idle"}, 64'(s), 64'h0);
    repeat (3) @(negedge clk);
  endtask

  task automatic queues_empty(input string req);
    chk(exp_f.size() == 0 && exp_s.size() == 0 && exp_w.size() == 0, {req, " all expected traffic seen"},
        64'(exp_f.size() + exp_s.size() + exp_w.size()), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 64'h0, 64'h1);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    logic [31:0] s;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mem_req && !src_req, "R1 no requests in reset", 64'({mem_req, src_req}), 64'h0);
    chk(!irq, "R1 irq low", 64'(irq), 64'h0);
    rst_n = 1'b1;
    rd(2'd1, s);
    chk(s == 32'h0, "R1 status zero", 64'(s), 64'h0);

    // R2 R3 R5 R11: single record
    put_desc(32'h000, 32'h0, 32'h1000_0000, 32'h400, 32'd16, 1'b1, 6'h09);
    wr(2'd0, 32'h000);
    irq_cnt = 0;
    wr(2'd1, 32'h1);
    rd(2'd1, s);
    chk(s[0], "R11 busy while running", 64'(s), 64'h1);
    wait_idle("R5");
    rd(2'd1, s);
    chk(s == 32'h2, "R5 done set, error clear", 64'(s), 64'h2);
    chk(irq_cnt == 1, "R5 single irq pulse", 64'(irq_cnt), 64'h1);
    queues_empty("R3");

    // R4 R6 R8: three records, zero-length in the middle, start while busy
    put_desc(32'h040, 32'h080, 32'h2000_0100, 32'h500, 32'd24, 1'b0, 6'h08);
    put_desc(32'h080, 32'h0C0, 32'h2000_9000, 32'h600, 32'd0, 1'b0, 6'h3F);
    put_desc(32'h0C0, 32'h000, 32'h3000_0000, 32'h700, 32'd12, 1'b1, 6'h2A);
    wr(2'd0, 32'h040);
    irq_cnt = 0;
    wr(2'd1, 32'h1);
    rd(2'd1, s);
    chk(s == 32'h1, "R11 start clears done", 64'(s), 64'h1);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h000);
    wr(2'd1, 32'h1);   // R8: must be ignored
    wait_idle("R4");
    rd(2'd1, s);
    chk(s == 32'h2, "R4 chain done", 64'(s), 64'h2);
    chk(irq_cnt == 1, "R8 one irq for one chain", 64'(irq_cnt), 64'h1);
    queues_empty("R6 R8");

    // R7: error on second record
    put_desc(32'h100, 32'h140, 32'h4000_0000, 32'h800, 32'd8, 1'b0, 6'h0D);
    put_desc(32'h140, 32'h180, 32'hE000_0000, 32'h900, 32'd8, 1'b0, 6'h0E);
    put_desc(32'h180, 32'h000, 32'h4000_1000, 32'hA00, 32'd8, 1'b1, 6'h0F);
    exp_f = exp_f[0:9];
    exp_s = exp_s[0:2];
    exp_w = exp_w[0:1];
    wr(2'd0, 32'h100);
    irq_cnt = 0;
    wr(2'd1, 32'h1);
    wait_idle("R7");
    repeat (10) @(negedge clk);
    rd(2'd1, s);
    chk(s == 32'h4, "R7 error set, done clear", 64'(s), 64'h4);
    rd(2'd2, s);
    chk(s == 32'h140, "R7 failing record address", 64'(s), 64'h140);
    chk(irq_cnt == 1, "R7 irq pulse", 64'(irq_cnt), 64'h1);
    queues_empty("R7");

    // R9: abort mid-block
    put_desc(32'h1C0, 32'h000, 32'h5000_0000, 32'hB00, 32'd64, 1'b1, 6'h01);
    wr(2'd0, 32'h1C0);
    irq_cnt = 0; wr_seen = 0; rd_seen = 0;
    wr(2'd1, 32'h1);
    rd(2'd1, s);
    chk(s == 32'h1, "R11 start clears error", 64'(s), 64'h1);
    while (wr_seen < 3) @(negedge clk);
    wr(2'd1, 32'h2);
    wait_idle("R9");
    repeat (10) @(negedge clk);
    chk(wr_seen == rd_seen, "R9 word in flight completed", 64'(wr_seen), 64'(rd_seen));
    chk(wr_seen < 16, "R9 block cut short", 64'(wr_seen), 64'd15);
    rd(2'd1, s);
    chk(s == 32'h0, "R9 no done after abort", 64'(s), 64'h0);
    chk(irq_cnt == 0, "R9 no irq after abort", 64'(irq_cnt), 64'h0);
    exp_f.delete(); exp_s.delete(); exp_w.delete();

    // R2 R5: rerun first list after abort
    put_desc(32'h000, 32'h0, 32'h1000_0000, 32'h400, 32'd16, 1'b1, 6'h09);
    wr(2'd0, 32'h000);
    wr(2'd1, 32'h1);
    wait_idle("R5");
    rd(2'd1, s);
    chk(s == 32'h2, "R5 done after rerun", 64'(s), 64'h2);
    queues_empty("R2");

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule